// File: doc/BRIEF.md
# Timer Host Command and Readback Port

This block is the byte-wide host side of a three-channel interval timer. The host sees four addresses. Addresses 0, 1 and 2 are the data ports of channels 0, 1 and 2. Address 3 takes command bytes. The block turns those accesses into three things:

- configuration strobes and reload-value strobes towards the counter channels;
- byte-sequenced reads of each channel's live count;
- frozen count snapshots and per-channel status bytes that the host collects later through the data ports.

The counters themselves sit outside the block. They supply a 16-bit live count, an output level and a null-count flag per channel. They accept a configuration strobe carrying six setup bits, and a reload strobe carrying a 16-bit value. A bus write or read is a single-cycle pulse. Read data is combinational during the pulse, and every side effect of an access takes place at the clock edge that ends it.

Top module: `tmr_host_if`

## Requirements
- R1: After reset every channel uses the low-then-high access mode (code 11), operating mode 0 and binary counting, with no snapshot and no status pending. A read of a data port returns the low byte of that channel's live count. `bus_rdata` is 0x00 whenever no data-port read is active, which includes reads of address 3.
- R2: A write to address 3 with bits 7:6 naming a channel (0 to 2) and bits 5:4 nonzero is a setup command for that channel. It pulses `cfg_we[ch]` in the same cycle, with `cfg_val` equal to the command's bits 5:0. Bits 5:4 are the access mode, bits 3:1 the operating mode and bit 0 the BCD flag. It also resets both byte pointers of that channel and discards its snapshot and its pending status.
- R3: A data-port write in access mode 01 (low only) pulses `reload_we` with reload value {0x00, data}. In access mode 10 (high only) the value is {data, 0x00}. The strobe comes in the same cycle as the write, and at most one strobe of any kind is active per cycle.
- R4: In access mode 11 the first data write after a setup command stores the low byte and raises no strobe. The next write pulses `reload_we` with {data, stored low byte}, and the pair then repeats.
- R5: Data-port reads return the low byte in mode 01 and the high byte in mode 10. In mode 11 they alternate, low byte first.
- R6: A command byte with bits 7:6 naming a channel and bits 5:4 = 00 snapshots that channel's live count at the clock edge of the write. Reads then return the snapshot instead of the live count until all of its bytes have been read: one byte in modes 01 and 10, two bytes in mode 11. After that, reads return the live count again.
- R7: A snapshot request for a channel that already holds an unread snapshot is ignored, and the older snapshot is kept.
- R8: A command byte with bits 7:6 = 11 is a read-back. Its bits 1, 2 and 3 select channels 0, 1 and 2. When bit 5 is 0, each selected channel takes a snapshot under the rules of R6 and R7.
- R9: When bit 4 of a read-back is 0, each selected channel captures a status byte at the command edge. The status byte holds the output level in bit 7, the null-count flag in bit 6, the access mode in bits 5:4, the operating mode in bits 3:1 and the BCD flag in bit 0. The next read of that data port returns the status byte, consumes it and leaves the byte pointers unchanged. A second status request on a channel whose status has not yet been read is ignored.
- R10: When a status byte and a snapshot are both pending on a channel, the status byte is returned first and the snapshot bytes follow.
- R11: When `bus_wr` and `bus_rd` are high in the same cycle, the write takes effect and the read is ignored. `bus_rdata` is 0x00 and no byte pointer, snapshot or status moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Single-cycle write pulse |
| bus_rd | input | 1 | Single-cycle read pulse |
| bus_addr | input | 2 | 0 to 2 channel data ports, 3 command port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while `bus_rd` is high |
| cnt_live | input | 48 | Live counts, channel n in bits 16n+15:16n |
| cnt_out | input | 3 | Output level of each channel |
| cnt_null | input | 3 | Null-count flag of each channel |
| reload_we | output | 3 | Reload strobe, one bit per channel |
| reload_val | output | 16 | Reload value accompanying the strobe |
| cfg_we | output | 3 | Setup strobe, one bit per channel |
| cfg_val | output | 6 | Access mode, operating mode and BCD flag |

## Verification
Two pieces of state can wait on the same data port at once: a status byte and a count snapshot. A single read-back with bits 5 and 4 both clear creates them in one edge. The bench issues such commands while the live counts keep moving. Its reference model then judges each read: the status byte must come first, and the snapshot bytes after it must match the count frozen at the command edge, not the count at read time.

// File: rtl/tmr_host_if.sv
`timescale 1ns/1ps
module tmr_host_if (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [1:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic [47:0] cnt_live,
  input  logic [2:0]  cnt_out,
  input  logic [2:0]  cnt_null,
  output logic [2:0]  reload_we,
  output logic [15:0] reload_val,
  output logic [2:0]  cfg_we,
  output logic [5:0]  cfg_val
);

  logic [1:0]  rw_q   [3];
  logic [2:0]  mode_q [3];
  logic        bcd_q  [3];
  logic        lat_q  [3];
  logic [15:0] latv_q [3];
  logic        st_q   [3];
  logic [7:0]  stv_q  [3];
  logic        rdhi_q [3];
  logic        wrhi_q [3];
  logic [7:0]  lo_q   [3];

  wire       wr_cmd = bus_wr & (bus_addr == 2'd3);
  wire       wr_dat = bus_wr & (bus_addr != 2'd3);
  wire       rd_go  = bus_rd & ~bus_wr & (bus_addr != 2'd3);
  wire [1:0] csel   = bus_wdata[7:6];
  wire       is_rb  = wr_cmd & (csel == 2'd3);
  wire       is_lat = wr_cmd & (csel != 2'd3) & (bus_wdata[5:4] == 2'b00);
  wire       is_cfg = wr_cmd & (csel != 2'd3) & (bus_wdata[5:4] != 2'b00);

  logic [2:0] cfg_hit, lat_req, st_req, rd_hit, wr_hit;

  always_comb begin
    for (int c = 0; c < 3; c++) begin
      cfg_hit[c] = is_cfg & (csel == 2'(c));
      lat_req[c] = (is_lat & (csel == 2'(c))) | (is_rb & ~bus_wdata[5] & bus_wdata[c+1]);
      st_req[c]  = is_rb & ~bus_wdata[4] & bus_wdata[c+1];
      rd_hit[c]  = rd_go & (bus_addr == 2'(c));
      wr_hit[c]  = wr_dat & (bus_addr == 2'(c));
    end
  end

  assign cfg_we  = cfg_hit;
  assign cfg_val = bus_wdata[5:0];

  always_comb begin
    logic [15:0] v;
    reload_we  = 3'b000;
    reload_val = 16'h0000;
    bus_rdata  = 8'h00;
    v          = 16'h0000;
    for (int c = 0; c < 3; c++) begin
      if (wr_hit[c]) begin
        case (rw_q[c])
          2'b01: begin reload_we[c] = 1'b1; reload_val = {8'h00, bus_wdata}; end
          2'b10: begin reload_we[c] = 1'b1; reload_val = {bus_wdata, 8'h00}; end
          2'b11: if (wrhi_q[c]) begin reload_we[c] = 1'b1; reload_val = {bus_wdata, lo_q[c]}; end
          default: ;
        endcase
      end
      if (rd_hit[c]) begin
        v = lat_q[c] ? latv_q[c] : cnt_live[c*16 +: 16];
        if (st_q[c])
          bus_rdata = stv_q[c];
        else if (rw_q[c] == 2'b10 || (rw_q[c] == 2'b11 && rdhi_q[c]))
          bus_rdata = v[15:8];
        else
          bus_rdata = v[7:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 3; c++) begin
        rw_q[c]   <= 2'b11;
        mode_q[c] <= 3'd0;
        bcd_q[c]  <= 1'b0;
        lat_q[c]  <= 1'b0;
        latv_q[c] <= 16'h0000;
        st_q[c]   <= 1'b0;
        stv_q[c]  <= 8'h00;
        rdhi_q[c] <= 1'b0;
        wrhi_q[c] <= 1'b0;
        lo_q[c]   <= 8'h00;
      end
    end else begin
      for (int c = 0; c < 3; c++) begin
        if (cfg_hit[c]) begin
          rw_q[c]   <= bus_wdata[5:4];
          mode_q[c] <= bus_wdata[3:1];
          bcd_q[c]  <= bus_wdata[0];
          lat_q[c]  <= 1'b0;
          st_q[c]   <= 1'b0;
          rdhi_q[c] <= 1'b0;
          wrhi_q[c] <= 1'b0;
        end else begin
          if (lat_req[c] && !lat_q[c]) begin
            lat_q[c]  <= 1'b1;
            latv_q[c] <= cnt_live[c*16 +: 16];
          end
          if (st_req[c] && !st_q[c]) begin
            st_q[c]  <= 1'b1;
            stv_q[c] <= {cnt_out[c], cnt_null[c], rw_q[c], mode_q[c], bcd_q[c]};
          end
          if (wr_hit[c] && rw_q[c] == 2'b11) begin
            wrhi_q[c] <= ~wrhi_q[c];
            if (!wrhi_q[c]) lo_q[c] <= bus_wdata;
          end
          if (rd_hit[c]) begin
            if (st_q[c]) st_q[c] <= 1'b0;
            else begin
              if (rw_q[c] == 2'b11) rdhi_q[c] <= ~rdhi_q[c];
              if (rw_q[c] != 2'b11 || rdhi_q[c]) lat_q[c] <= 1'b0;
            end
          end
        end
      end
    end
  end

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reload_we, cfg_we}));

  for (genvar g = 0; g < 3; g++) begin : g_chk
    // R6
    snap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lat_q[g] && !cfg_hit[g]) |=> $stable(latv_q[g]));
    // R4
    low_first_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_hit[g] && bus_wdata[5:4] == 2'b11) |=> !reload_we[g]);
    // R9
    status_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit[g] && st_q[g]) |=> !st_q[g]);
    // R2
    setup_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_hit[g] |=> (!lat_q[g] && !st_q[g]));
  end

endmodule

// File: tb/tmr_host_if_tb_top.sv
`timescale 1ns/1ps
module tmr_host_if_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [1:0]  bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic [15:0] cnt [3];
  logic [47:0] cnt_live;
  logic [2:0]  cnt_out, cnt_null;
  logic [2:0]  reload_we, cfg_we;
  logic [15:0] reload_val;
  logic [5:0]  cfg_val;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  int m_rw[3], m_mode[3], m_bcd[3], m_lat[3], m_latv[3], m_st[3], m_stv[3], m_rh[3], m_wh[3], m_lo[3];

  always #2.5 clk = ~clk;
  assign cnt_live = {cnt[2], cnt[1], cnt[0]};

  tmr_host_if dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_live(cnt_live), .cnt_out(cnt_out),
    .cnt_null(cnt_null), .reload_we(reload_we), .reload_val(reload_val),
    .cfg_we(cfg_we), .cfg_val(cfg_val));

  task automatic chk(input string what, input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic snap(input int c);
    if (m_lat[c] == 0) begin m_lat[c] = 1; m_latv[c] = int'(cnt[c]); end
  endtask

  task automatic cyc(input bit w, input bit r, input logic [1:0] a, input logic [7:0] d, input string tag);
    int e_rd, e_we, e_val, e_cw, v, ai;
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
    for (int c = 0; c < 3; c++) cnt[c] = cnt[c] - 16'(c * 7 + 3);
    cnt_out = 3'($urandom); cnt_null = 3'($urandom);
    #2;
    ai = int'(a);
    e_rd = 0; e_we = 0; e_val = 0; e_cw = 0;
    if (w && ai == 3 && d[7:6] != 2'd3 && d[5:4] != 2'b00) e_cw = 1 << d[7:6];
    if (w && ai != 3) begin
      if (m_rw[ai] == 1) begin e_we = 1 << ai; e_val = int'(d); end
      else if (m_rw[ai] == 2) begin e_we = 1 << ai; e_val = int'(d) << 8; end
      else if (m_rw[ai] == 3 && m_wh[ai] == 1) begin e_we = 1 << ai; e_val = (int'(d) << 8) | m_lo[ai]; end
    end
    if (r && !w && ai != 3) begin
      v = m_lat[ai] ? m_latv[ai] : int'(cnt[ai]);
      if (m_st[ai]) e_rd = m_stv[ai];
      else if (m_rw[ai] == 2 || (m_rw[ai] == 3 && m_rh[ai] == 1)) e_rd = (v >> 8) & 255;
      else e_rd = v & 255;
    end
    chk("rdata", tag, int'(bus_rdata), e_rd);
    chk("reload_we", tag, int'(reload_we), e_we);
    if (e_we != 0) chk("reload_val", tag, int'(reload_val), e_val);
    chk("cfg_we", tag, int'(cfg_we), e_cw);
    if (e_cw != 0) chk("cfg_val", tag, int'(cfg_val), int'(d[5:0]));
    @(posedge clk);
    if (w && ai == 3) begin
      if (d[7:6] != 2'd3) begin
        if (d[5:4] == 2'b00) snap(int'(d[7:6]));
        else begin
          int c = int'(d[7:6]);
          m_rw[c] = int'(d[5:4]); m_mode[c] = int'(d[3:1]); m_bcd[c] = int'(d[0]);
          m_lat[c] = 0; m_st[c] = 0; m_rh[c] = 0; m_wh[c] = 0;
        end
      end else begin
        for (int c = 0; c < 3; c++) if (d[c+1]) begin
          if (!d[5]) snap(c);
          if (!d[4] && m_st[c] == 0) begin
            m_st[c] = 1;
            m_stv[c] = (int'(cnt_out[c]) << 7) | (int'(cnt_null[c]) << 6) | (m_rw[c] << 4) | (m_mode[c] << 1) | m_bcd[c];
          end
        end
      end
    end else if (w) begin
      if (m_rw[ai] == 3) begin
        if (m_wh[ai] == 0) m_lo[ai] = int'(d);
        m_wh[ai] ^= 1;
      end
    end else if (r && ai != 3) begin
      if (m_st[ai]) m_st[ai] = 0;
      else begin
        if (m_rw[ai] != 3 || m_rh[ai] == 1) m_lat[ai] = 0;
        if (m_rw[ai] == 3) m_rh[ai] ^= 1;
      end
    end
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input string tag);
    cyc(1, 0, a, d, tag);
  endtask
  task automatic rd(input logic [1:0] a, input string tag);
    cyc(0, 1, a, 8'h00, tag);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 2'd0, 8'h00, "idle");
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0; cnt_out = 0; cnt_null = 0;
    cnt[0] = 16'h1234; cnt[1] = 16'hA5C3; cnt[2] = 16'h0F0F;
    for (int c = 0; c < 3; c++) begin
      m_rw[c] = 3; m_mode[c] = 0; m_bcd[c] = 0; m_lat[c] = 0; m_latv[c] = 0;
      m_st[c] = 0; m_stv[c] = 0; m_rh[c] = 0; m_wh[c] = 0; m_lo[c] = 0;
    end
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(2'd0, "R1"); rd(2'd0, "R1"); rd(2'd3, "R1"); idle(1);
    // R2, R3, R5 low-only and high-only
    wr(2'd3, 8'b00_01_010_1, "R2"); wr(2'd0, 8'h5A, "R3"); rd(2'd0, "R5"); rd(2'd0, "R5");
    wr(2'd3, 8'b01_10_011_0, "R2"); wr(2'd1, 8'hC7, "R3"); rd(2'd1, "R5");
    // R4, R5 low-then-high
    wr(2'd3, 8'b10_11_100_0, "R2"); wr(2'd2, 8'h11, "R4"); wr(2'd2, 8'h22, "R4");
    wr(2'd2, 8'h33, "R4"); wr(2'd2, 8'h44, "R4");
    rd(2'd2, "R5"); rd(2'd2, "R5"); rd(2'd2, "R5");
    rd(2'd2, "R5");
    // R6 snapshot and release
    wr(2'd3, 8'b10_00_0000, "R6"); idle(3); rd(2'd2, "R6"); idle(2); rd(2'd2, "R6"); rd(2'd2, "R6");
    wr(2'd3, 8'b00_00_0000, "R6"); idle(2); rd(2'd0, "R6"); rd(2'd0, "R6");
    // R7 repeated snapshot ignored
    wr(2'd3, 8'b01_00_0000, "R7"); idle(2); wr(2'd3, 8'b01_00_0000, "R7"); idle(2);
    rd(2'd1, "R7"); rd(2'd1, "R7");
    // R2 setup discards snapshot
    wr(2'd3, 8'b00_00_0000, "R2"); idle(1); wr(2'd3, 8'b00_11_000_0, "R2"); rd(2'd0, "R2"); rd(2'd0, "R2");
    // R8 read-back snapshot of all channels
    wr(2'd3, 8'b1101_1110, "R8"); idle(2);
    rd(2'd0, "R8"); rd(2'd1, "R8"); rd(2'd2, "R8"); rd(2'd0, "R8"); rd(2'd2, "R8");
    rd(2'd0, "R8"); rd(2'd2, "R8");
    // R9 status only, second request ignored while pending
    wr(2'd3, 8'b1110_0010, "R9"); idle(1); wr(2'd3, 8'b1110_0010, "R9");
    rd(2'd0, "R9"); rd(2'd0, "R9"); rd(2'd0, "R9");
    // R10 status before snapshot
    wr(2'd3, 8'b1100_0100, "R10"); idle(2); rd(2'd1, "R10"); rd(2'd1, "R10"); rd(2'd1, "R10");
    wr(2'd3, 8'b1100_1000, "R10"); idle(1); rd(2'd2, "R10"); rd(2'd2, "R10"); rd(2'd2, "R10"); rd(2'd2, "R10");
    // R11 simultaneous write and read
    wr(2'd3, 8'b10_11_000_0, "R11"); cyc(1, 1, 2'd2, 8'h66, "R11"); rd(2'd2, "R11");
    cyc(1, 1, 2'd2, 8'h77, "R11"); rd(2'd2, "R11"); rd(2'd2, "R11");
    // mixed traffic
    for (int i = 0; i < 1500; i++) begin
      int k = $urandom_range(0, 9);
      if (k < 3) wr(2'd3, 8'($urandom), "mixed");
      else if (k < 5) wr(2'($urandom_range(0, 2)), 8'($urandom), "mixed");
      else if (k < 9) rd(2'($urandom_range(0, 3)), "mixed");
      else cyc(1, 1, 2'($urandom), 8'($urandom), "mixed");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule